// File: doc/BRIEF.md
# Loss-Alarm Interrupt and Status Register

This block watches three line-condition inputs: loss of signal, alarm indication and network loopback. It pulls an active-low interrupt line when any of them changes state. The host owns one control register that holds one bit per source, and each bit has two meanings. Writing 1 acknowledges the pending change and masks that source. Writing 0 unmasks the source but leaves any pending change in place. Reads never clear anything.

A read-only status register packs the loopback and all-ones-transmit conditions, together with the pending change events, into a 3-bit code in the top bits of the byte. The meaning of that code depends on a long-haul or short-haul mode strap, and when several conditions hold at once a fixed priority picks the code.

All six condition inputs pass through a multi-flop synchronizer before use. The host reaches the block over a plain address, write strobe and read strobe bus. Read data is combinational and valid while the read strobe is high. There is no streaming data path, so every pin is a plain control or status signal.

Top module: `lai_alarm_regs`

## Requirements
- R1: After reset, irq_n is 1, the status register reads 0x00 and the control register reads 0x00, which means every source is unmasked.
- R2: A change in either direction of los_i, ais_i or nloop_i on an unmasked source records a pending event and drives irq_n low by the third rising clock edge after the change. irq_n stays low while any event is pending.
- R3: A host write to the control address (0x11) with bit 0 (loss of signal), bit 1 (alarm) or bit 2 (network loopback) set clears that source's pending event and masks the source. irq_n returns high only when no other event remains pending.
- R4: A change on a masked source records no event and leaves irq_n unchanged.
- R5: Writing 0 to a control bit unmasks that source without clearing its pending event, and a later change on that source raises the interrupt again.
- R6: Host reads of either register change neither irq_n nor the status code.
- R7: Reading the control address returns the mask bits in bits 2:0 and zero in the other bits. Reading any address other than 0x10 or 0x11 returns 0x00.
- R8: The status register (address 0x10) carries its code in bits 7:5, with bits 4:0 zero. With no events pending, the codes are: 001 for remote loopback only, 010 for local loopback without all-ones, 100 for all-ones without local loopback, 110 for all-ones together with local loopback, and 000 when none of these holds.
- R9: In long-haul mode (long_haul_i = 1), the change codes are 011 for a pending loss-of-signal event, 101 for a pending network-loopback event, and 111 when both are pending.
- R10: In short-haul mode, a pending network-loopback event does not appear in the status code, and codes 101 and 111 never appear.
- R11: Priority runs as follows: the combined change code, then the single change codes (network loopback before loss of signal), then the loopback and all-ones codes, then 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| los_i | input | 1 | Loss-of-signal condition, asynchronous |
| ais_i | input | 1 | Alarm-indication condition, asynchronous |
| nloop_i | input | 1 | Network loopback condition, asynchronous |
| rloop_i | input | 1 | Remote loopback active |
| lloop_i | input | 1 | Local loopback active |
| taos_i | input | 1 | All-ones transmit active |
| long_haul_i | input | 1 | Mode strap: 1 long-haul, 0 short-haul |
| host_addr | input | 8 | Register address |
| host_wr | input | 1 | Write strobe, one cycle |
| host_wdata | input | 8 | Write data |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | 8 | Read data, valid while host_rd is high |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with its default parameters: a two-stage synchronizer, an 8-bit bus, status at 0x10 and control at 0x11. With these values the exact three-edge event latency and the field positions named in the requirements can be checked. They also let the bench reach every status code, including the long-haul combined code and the short-haul case in which a pending network-loopback event stays hidden behind the all-ones code. Mode switching on a live pending event shows that the strap changes only the encoding and never the stored events.

// File: rtl/lai_pkg.sv
package lai_pkg;
  localparam int NUM_EVT = 3;
  localparam int EV_LOS  = 0;
  localparam int EV_AIS  = 1;
  localparam int EV_NLP  = 2;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'b000,
    ST_RLOOP      = 3'b001,
    ST_LLOOP      = 3'b010,
    ST_LOS_CHG    = 3'b011,
    ST_TAOS       = 3'b100,
    ST_NLP_CHG    = 3'b101,
    ST_TAOS_LLOOP = 3'b110,
    ST_BOTH_CHG   = 3'b111
  } stat_code_e;
endpackage

// File: rtl/lai_sync.sv
module lai_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/lai_event_bank.sv
module lai_event_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cond,
  input  logic         wr_ctrl,
  input  logic [N-1:0] wr_bits,
  output logic [N-1:0] chg,
  output logic [N-1:0] evt,
  output logic [N-1:0] mask
);
  logic [N-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= cond;
  end

  assign chg = cond ^ prev;

  for (genvar i = 0; i < N; i++) begin : g_src
    // Write of 1 wins over a simultaneous change.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        evt[i]  <= 1'b0;
        mask[i] <= 1'b0;
      end else begin
        if (wr_ctrl) mask[i] <= wr_bits[i];
        if (wr_ctrl && wr_bits[i])    evt[i] <= 1'b0;
        else if (chg[i] && !mask[i])  evt[i] <= 1'b1;
      end
    end

    a_r3_wr1_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && wr_bits[i]) |=> (!evt[i] && mask[i]));

    a_r4_masked_stays_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (mask[i] && !evt[i]) |=> !evt[i]);

    a_r5_wr0_keeps_event: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && !wr_bits[i] && evt[i]) |=> (evt[i] && !mask[i]));
  end
endmodule

// File: rtl/lai_status_enc.sv
module lai_status_enc
  import lai_pkg::*;
(
  input  logic       long_haul,
  input  logic       los_evt,
  input  logic       nlp_evt,
  input  logic       rloop,
  input  logic       lloop,
  input  logic       taos,
  output stat_code_e code
);
  logic nlp_vis;
  assign nlp_vis = nlp_evt && long_haul;

  always_comb begin
    if (los_evt && nlp_vis)  code = ST_BOTH_CHG;
    else if (nlp_vis)        code = ST_NLP_CHG;
    else if (los_evt)        code = ST_LOS_CHG;
    else if (taos && lloop)  code = ST_TAOS_LLOOP;
    else if (taos)           code = ST_TAOS;
    else if (lloop)          code = ST_LLOOP;
    else if (rloop)          code = ST_RLOOP;
    else                     code = ST_IDLE;
  end

  always_comb begin
    if (!long_haul)
      a_r10_short_codes: assert (code != ST_NLP_CHG && code != ST_BOTH_CHG);
  end
endmodule

// File: rtl/lai_alarm_regs.sv
module lai_alarm_regs
  import lai_pkg::*;
#(
  parameter int              SYNC_STAGES = 2,
  parameter int              ADDR_W      = 8,
  parameter int              DATA_W      = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              los_i,
  input  logic              ais_i,
  input  logic              nloop_i,
  input  logic              rloop_i,
  input  logic              lloop_i,
  input  logic              taos_i,
  input  logic              long_haul_i,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_rd,
  output logic [DATA_W-1:0] host_rdata,
  output logic              irq_n
);
  localparam int CODE_W   = 3;
  localparam int CODE_LSB = DATA_W - CODE_W;
  localparam int RAW_W    = 6;

  logic [RAW_W-1:0]   raw, syn;
  logic [NUM_EVT-1:0] cond, chg, evt, mask;
  logic               wr_ctrl;
  stat_code_e         code;

  assign raw = {taos_i, lloop_i, rloop_i, nloop_i, ais_i, los_i};

  lai_sync #(.W(RAW_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
  );

  assign cond    = syn[NUM_EVT-1:0];
  assign wr_ctrl = host_wr && (host_addr == CTRL_ADDR);

  lai_event_bank #(.N(NUM_EVT)) u_bank (
    .clk(clk), .rst_n(rst_n), .cond(cond), .wr_ctrl(wr_ctrl),
    .wr_bits(host_wdata[NUM_EVT-1:0]), .chg(chg), .evt(evt), .mask(mask)
  );

  lai_status_enc u_enc (
    .long_haul(long_haul_i), .los_evt(evt[EV_LOS]), .nlp_evt(evt[EV_NLP]),
    .rloop(syn[3]), .lloop(syn[4]), .taos(syn[5]), .code(code)
  );

  assign irq_n = ~(|evt);

  always_comb begin
    host_rdata = '0;
    if (host_rd) begin
      if (host_addr == STAT_ADDR)
        host_rdata = {code, {CODE_LSB{1'b0}}};
      else if (host_addr == CTRL_ADDR)
        host_rdata = {{(DATA_W-NUM_EVT){1'b0}}, mask};
    end
  end

  a_r2_change_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (|(chg & ~mask) && !host_wr) |=> !irq_n);

  a_r6_read_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr && !(|chg)) |=> ($stable(evt) && $stable(mask)));

  a_r1_irq_quiet_without_events: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_n && !(|chg)) |=> irq_n);
endmodule

// File: tb/test_lai_alarm_regs.sv
module test_lai_alarm_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       los_i = 0, ais_i = 0, nloop_i = 0, rloop_i = 0, lloop_i = 0, taos_i = 0;
  logic       long_haul_i = 1'b1;
  logic [7:0] host_addr = '0;
  logic       host_wr = 1'b0;
  logic [7:0] host_wdata = '0;
  logic       host_rd = 1'b0;
  logic [7:0] host_rdata;
  logic       irq_n;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #2.5 clk = ~clk;

  lai_alarm_regs i_lai_alarm_regs (
    .clk(clk), .rst_n(rst_n), .los_i(los_i), .ais_i(ais_i), .nloop_i(nloop_i),
    .rloop_i(rloop_i), .lloop_i(lloop_i), .taos_i(taos_i), .long_haul_i(long_haul_i),
    .host_addr(host_addr), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata), .irq_n(irq_n)
  );

  // Monitor: pops expected read data while a read is on the bus.
  always @(negedge clk) begin
    if (host_rd && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (host_rdata !== e) begin
        bad++;
        $display("FAIL %s: rdata actual=%02h expected=%02h", t, host_rdata, e);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
    @(posedge clk); #1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    host_addr = a;
    host_rd = 1'b1;
    @(posedge clk); #1;
    host_rd = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    @(posedge clk); #1;
    host_addr = 8'h11;
    host_wdata = d;
    host_wr = 1'b1;
    @(posedge clk); #1;
    host_wr = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    total++;
    if (irq_n !== e) begin
      bad++;
      $display("FAIL %s: irq_n actual=%0b expected=%0b", t, irq_n, e);
    end
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    chk_irq(1'b1, "R1 reset irq");
    rd(8'h10, 8'h00, "R1 reset status");
    rd(8'h11, 8'h00, "R1 reset ctrl");
    rd(8'h33, 8'h00, "R7 unmapped address");

    // R2 latency: event visible after third rising edge
    @(posedge clk); #1;
    los_i = 1'b1;
    tick(2);
    chk_irq(1'b1, "R2 not yet after two edges");
    tick(1);
    chk_irq(1'b0, "R2 irq after three edges");
    rd(8'h10, 8'h60, "R9 los change code");
    rd(8'h10, 8'h60, "R6 repeated read");
    chk_irq(1'b0, "R6 read leaves irq");

    wr(8'h01);
    chk_irq(1'b1, "R3 write one clears");
    rd(8'h11, 8'h01, "R7 ctrl shows mask");
    rd(8'h10, 8'h00, "R3 status cleared");

    los_i = 1'b0;
    tick(4);
    chk_irq(1'b1, "R4 masked los ignored");
    rd(8'h10, 8'h00, "R4 masked los no status");

    ais_i = 1'b1;
    tick(4);
    chk_irq(1'b0, "R2 alarm change");
    rd(8'h10, 8'h00, "R8 alarm not in code");
    wr(8'h03);
    chk_irq(1'b1, "R3 alarm acknowledged");
    rd(8'h11, 8'h03, "R7 ctrl two masks");

    wr(8'h00);
    chk_irq(1'b1, "R5 unmask keeps irq high");
    rd(8'h11, 8'h00, "R5 all unmasked");
    nloop_i = 1'b1;
    tick(4);
    chk_irq(1'b0, "R2 nloop change");
    rd(8'h10, 8'hA0, "R9 nloop change code");
    los_i = 1'b1;
    tick(4);
    rd(8'h10, 8'hE0, "R9 both change code");
    long_haul_i = 1'b0;
    rd(8'h10, 8'h60, "R10 short haul hides nloop");
    long_haul_i = 1'b1;
    wr(8'h01);
    chk_irq(1'b0, "R3 nloop still pending");
    rd(8'h10, 8'hA0, "R11 nloop code after los clear");
    wr(8'h04);
    chk_irq(1'b1, "R3 last event cleared");
    rd(8'h10, 8'h00, "R3 status idle");

    // Pending event survives unmask, and re-arms
    wr(8'h00);
    ais_i = 1'b0;
    tick(4);
    wr(8'h05);
    chk_irq(1'b0, "R5 write zero keeps alarm event");
    wr(8'h02);
    chk_irq(1'b1, "R3 alarm cleared");

    rloop_i = 1'b1;
    tick(4);
    rd(8'h10, 8'h20, "R8 remote loopback");
    lloop_i = 1'b1;
    tick(4);
    rd(8'h10, 8'h40, "R8 local over remote");
    taos_i = 1'b1;
    tick(4);
    rd(8'h10, 8'hC0, "R8 all-ones with local");
    lloop_i = 1'b0;
    tick(4);
    rd(8'h10, 8'h80, "R8 all-ones only");
    chk_irq(1'b1, "R8 status inputs raise nothing");

    wr(8'h00);
    los_i = 1'b0;
    tick(4);
    rd(8'h10, 8'h60, "R11 change over all-ones");
    long_haul_i = 1'b0;
    nloop_i = 1'b0;
    tick(4);
    rd(8'h10, 8'h60, "R10 short haul los code");
    wr(8'h01);
    chk_irq(1'b0, "R2 nloop pending in short haul");
    rd(8'h10, 8'h80, "R10 hidden nloop shows all-ones");
    long_haul_i = 1'b1;
    rd(8'h10, 8'hA0, "R9 mode switch reveals nloop");

    tick(2);
    if (exp_q.size() != 0) begin
      total++;
      bad++;
      $display("FAIL R6: %0d reads unchecked expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1: watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule